// File: doc/BRIEF.md
# Register-Dependence Interlock for a Five-Stage Pipeline

This block is the hazard interlock of an in-order pipeline with fetch, decode, execute, memory and writeback stages and no operand bypass. An instruction in decode can only take its operands from the register file. The register file cannot return a value in the same cycle it is written. A reader that depends on an older instruction must therefore wait in decode until the cycle after that producer has been in writeback.

The block keeps its own record of the destination register held in each of execute, memory and writeback. It builds that record from the decode slot: an advancing instruction brings its destination, and a bubble brings none. Every cycle it compares each source field of the decode instruction against that record. On a match it holds the fetch and decode pipeline registers and injects a bubble into execute. The datapath uses the three outputs as enables and as a select.

Top module: `dep_stall_ctrl`

## Requirements
- R1: When the decode slot is valid and one of its sources matches a valid destination in execute, memory or writeback, `hold_decode` is high in that same cycle. It drops in the first cycle after the last matching producer has left writeback.
- R2: A reader directly behind its producer sees `hold_decode` high for exactly 3 cycles, so it is presented in decode for 4 cycles in total. No hold run lasts longer than 3 cycles.
- R3: With k-1 other slots between producer and reader, the reader holds for 4-k cycles: 2 cycles for k=2, 1 cycle for k=3 and none for k of 4 or more. Every hold cycle adds exactly one cycle to the run. A stream with no dependences advances one instruction per cycle.
- R4: `hold_fetch` equals `hold_decode` in every cycle.
- R5: `inject_bubble` is high exactly in held cycles. A bubble carries no destination, so it never delays a later reader.
- R6: Register code 15 (all ones at the default 4-bit width) means no register. As a source it never matches anything, and as a destination it is never matched.
- R7: When `dec_valid` is low, no hold is raised whatever the source fields hold. The empty slot moves on as a bubble and still counts as a slot of distance.
- R8: Source 0 sits in `dec_src[3:0]` and source 1 in `dec_src[7:4]`. Either source can cause a hold. When both match, the hold lasts as long as the youngest producer requires.
- R9: A synchronous active-low reset empties execute, memory and writeback. After reset no source causes a hold, even if a hold was in progress when reset was asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid | input | 1 | Decode slot holds a real instruction |
| dec_src | input | NUM_SRC*REG_W (8) | Source register numbers, source 0 in the low field |
| dec_dst | input | REG_W (4) | Destination register number of the decode instruction |
| hold_fetch | output | 1 | Keep the fetch pipeline register |
| hold_decode | output | 1 | Keep the decode pipeline register |
| inject_bubble | output | 1 | Load execute with a no-op that has no destination |

## Verification
The assertions that follow a hold forward in time take one thing for granted: while `hold_decode` is high, the decode inputs stay unchanged. A held instruction cannot alter its own source fields, and a new one cannot take its place until it moves on. The bench's instruction-stream model keeps to this rule. It changes `dec_valid`, `dec_src` and `dec_dst` only after a cycle in which the hold was low, and it keeps a held reader in place through a reset. Register codes in the stimulus use the all-ones value only to mean "no register".

// File: rtl/dep_stall_pkg.sv
// Shared constants for the register-dependence interlock.
// Assumes: register numbers are unsigned, and the all-ones code is "no register".
package dep_stall_pkg;
    localparam int DEF_REG_W     = 4;   // bits per register number
    localparam int DEF_SRC_PORTS = 2;   // source fields per instruction
    localparam int DEF_DEPTH     = 3;   // stages after decode that still owe a write

    // Code reserved for "no register" at a given width
    function automatic int none_code(input int width);
        return (1 << width) - 1;
    endfunction
endpackage

// File: rtl/dep_dst_track.sv
// Shadow record of the destination register held in each stage after decode.
// Entry 0 is execute and entry DEPTH-1 is writeback; the record shifts every cycle.
// Assumes: the caller presents the "no register" code for a bubble.
module dep_dst_track #(
    parameter int REG_W = dep_stall_pkg::DEF_REG_W,
    parameter int DEPTH = dep_stall_pkg::DEF_DEPTH
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [REG_W-1:0]       ins_dst,
    output logic [DEPTH*REG_W-1:0] stage_dst
);
    localparam logic [REG_W-1:0] NONE_CODE = REG_W'(dep_stall_pkg::none_code(REG_W));

    logic [REG_W-1:0] dst_q [DEPTH];

    // Execute stage takes whatever leaves decode (a destination or the empty code)
    always_ff @(posedge clk) begin
        if (!rst_n) dst_q[0] <= NONE_CODE;
        else        dst_q[0] <= ins_dst;
    end

    // Later stages take the entry of the stage before them
    for (genvar g = 1; g < DEPTH; g++) begin : g_shift
        always_ff @(posedge clk) begin
            if (!rst_n) dst_q[g] <= NONE_CODE;
            else        dst_q[g] <= dst_q[g-1];
        end
    end

    // Flatten the record for the comparators
    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign stage_dst[g*REG_W +: REG_W] = dst_q[g];
    end

    // Reset leaves every stage empty
    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> (dst_q[0] == NONE_CODE && dst_q[DEPTH-1] == NONE_CODE));  // R9

    // Each record entry moves one stage per cycle
    AST_RECORD_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> dst_q[DEPTH-1] == $past(dst_q[DEPTH-2]));  // R3
endmodule

// File: rtl/dep_src_match.sv
// Compares one source register number against every tracked destination.
// Produces one hit bit per stage. The empty code never hits.
// Assumes: the stage_dst layout produced by dep_dst_track.
module dep_src_match #(
    parameter int REG_W = dep_stall_pkg::DEF_REG_W,
    parameter int DEPTH = dep_stall_pkg::DEF_DEPTH
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   src_valid,
    input  logic [REG_W-1:0]       src_reg,
    input  logic [DEPTH*REG_W-1:0] stage_dst,
    output logic [DEPTH-1:0]       hit
);
    localparam logic [REG_W-1:0] NONE_CODE = REG_W'(dep_stall_pkg::none_code(REG_W));

    logic src_real;

    // A source takes part only if the slot is live and the field names a register
    assign src_real = src_valid && (src_reg != NONE_CODE);

    // One equality comparator per tracked stage
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = src_real && (stage_dst[g*REG_W +: REG_W] == src_reg);
    end

    // An empty source field never raises a hit
    AST_NONE_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (src_reg == NONE_CODE) |-> (hit == '0));  // R6
endmodule

// File: rtl/dep_stall_ctrl.sv
// Register-dependence interlock for a five-stage in-order pipeline without bypass.
// Holds fetch and decode, and injects an execute bubble, while any decode source
// matches a destination still in execute, memory or writeback.
// Assumes: the decode inputs stay unchanged while hold_decode is high.
module dep_stall_ctrl #(
    parameter int REG_W   = dep_stall_pkg::DEF_REG_W,
    parameter int NUM_SRC = dep_stall_pkg::DEF_SRC_PORTS,
    parameter int DEPTH   = dep_stall_pkg::DEF_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dec_valid,
    input  logic [NUM_SRC*REG_W-1:0] dec_src,
    input  logic [REG_W-1:0]         dec_dst,
    output logic                     hold_fetch,
    output logic                     hold_decode,
    output logic                     inject_bubble
);
    localparam logic [REG_W-1:0] NONE_CODE = REG_W'(dep_stall_pkg::none_code(REG_W));
    localparam int               RUN_W     = $clog2(DEPTH + 2);
    localparam logic [DEPTH-1:0] WB_ONLY   = DEPTH'(1) << (DEPTH - 1);

    logic [DEPTH*REG_W-1:0] stage_dst;
    logic [DEPTH-1:0]       src_hit [NUM_SRC];
    logic [DEPTH-1:0]       hit_stage;
    logic                   hold;
    logic [REG_W-1:0]       adv_dst;
    logic [RUN_W-1:0]       run_q;

    // Destination that enters execute: the real one on advance, none on a bubble
    assign adv_dst = (dec_valid && !hold) ? dec_dst : NONE_CODE;

    dep_dst_track #(.REG_W(REG_W), .DEPTH(DEPTH)) track_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_dst   (adv_dst),
        .stage_dst (stage_dst)
    );

    // One comparator bank per source field of the decode instruction
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        dep_src_match #(.REG_W(REG_W), .DEPTH(DEPTH)) match_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_valid (dec_valid),
            .src_reg   (dec_src[s*REG_W +: REG_W]),
            .stage_dst (stage_dst),
            .hit       (src_hit[s])
        );
    end

    // Merge the per-source hits into one hit vector per stage
    always_comb begin
        hit_stage = '0;
        for (int s = 0; s < NUM_SRC; s++) hit_stage = hit_stage | src_hit[s];
    end

    // Any pending write to a needed register holds the front of the pipe
    assign hold          = |hit_stage;
    assign hold_decode   = hold;
    assign hold_fetch    = hold;
    assign inject_bubble = hold;

    // Length of the current hold run, kept for the bound check
    always_ff @(posedge clk) begin
        if (!rst_n)                     run_q <= '0;
        else if (!hold)                 run_q <= '0;
        else if (run_q != '1)           run_q <= run_q + 1'b1;
    end

    // An empty decode slot never stalls
    AST_NO_STALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !hold_decode);  // R7

    // A producer seen in execute is still pending one cycle later
    AST_EX_HIT_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && hit_stage[0]) |=> hold_decode);  // R2

    // A match only in writeback is released in the next cycle
    AST_WB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_stage == WB_ONLY) |=> !hold_decode);  // R1

    // No hold run is longer than the stages that can owe a write
    AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (run_q < RUN_W'(DEPTH)));  // R2

    // A held cycle sends no destination into execute
    AST_BUBBLE_NO_DST: assert property (@(posedge clk) disable iff (!rst_n)
        inject_bubble |=> (stage_dst[REG_W-1:0] == NONE_CODE));  // R5

    // An advancing live instruction carries its destination into execute
    AST_ADVANCE_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !hold) |=> (stage_dst[REG_W-1:0] == $past(dec_dst)));  // R3
endmodule

// File: tb/dep_stall_ctrl_tb.sv
`timescale 1ns/1ps
module dep_stall_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_valid = 1'b0;
    logic [7:0] dec_src = 8'hFF;
    logic [3:0] dec_dst = 4'hF;
    logic       hold_fetch, hold_decode, inject_bubble;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    int got_stall;
    int start_cyc;

    always #2.5 clk = ~clk;

    dep_stall_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .dec_valid     (dec_valid),
        .dec_src       (dec_src),
        .dec_dst       (dec_dst),
        .hold_fetch    (hold_fetch),
        .hold_decode   (hold_decode),
        .inject_bubble (inject_bubble)
    );

    // Stream entries {src0, src1, dst, expected hold cycles}; F = no register
    localparam int NV = 17;
    localparam logic [15:0] VEC [NV] = '{
        16'hFF10, 16'h1F23, 16'hFF30, 16'h2F42, 16'hFF50, 16'hFF60,
        16'h4F71, 16'hFF80, 16'hFF90, 16'hFFA0, 16'h7FB0, 16'hFBC3,
        16'hFFF0, 16'hFFD0, 16'hDCE3, 16'h0F00, 16'h0013
    };

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one instruction in decode, count its hold cycles, then let it advance
    task automatic issue(input logic [3:0] s0, input logic [3:0] s1, input logic [3:0] d);
        dec_valid = 1'b1;
        dec_src   = {s1, s0};
        dec_dst   = d;
        got_stall = 0;
        #1;
        while (hold_decode && got_stall < 20) begin
            check("R4 fetch hold follows decode hold", int'(hold_fetch), 1);
            check("R5 bubble during hold", int'(inject_bubble), 1);
            got_stall++;
            @(negedge clk);
            #1;
        end
        check("R5 no bubble on advance", int'(inject_bubble), 0);
        @(negedge clk);
    endtask

    task automatic idle_slot(input logic [3:0] s0);
        dec_valid = 1'b0;
        dec_src   = {4'hF, s0};
        dec_dst   = 4'hF;
        #1;
        check("R7 empty slot never holds", int'(hold_decode), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R9 reset hold_decode", int'(hold_decode), 0);
        check("R9 reset hold_fetch", int'(hold_fetch), 0);
        check("R9 reset inject_bubble", int'(inject_bubble), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R6 R8 stall lengths for each stream entry
        start_cyc = cyc;
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][15:12], VEC[i][11:8], VEC[i][7:4]);
            check($sformatf("R1 R2 R3 R6 R8 hold cycles entry %0d", i),
                  got_stall, int'(VEC[i][3:0]));
        end
        check("R3 total cycles equal entries plus holds", cyc - start_cyc, NV + 15);

        // R7: an empty slot with matching source fields, then a reader at distance 2
        issue(4'hF, 4'hF, 4'h5);
        idle_slot(4'h5);
        issue(4'h5, 4'hF, 4'h1);
        check("R7 empty slot counts as distance", got_stall, 2);

        // R5: bubbles while B waits carry no destination; C reads A's register freely
        issue(4'hF, 4'hF, 4'h6);
        issue(4'h6, 4'hF, 4'h9);
        check("R2 adjacent reader", got_stall, 3);
        issue(4'h6, 4'hF, 4'h2);
        check("R5 bubble has no destination", got_stall, 0);

        // R6: a producer with no destination followed by a reader of code 15
        issue(4'hF, 4'hF, 4'hF);
        issue(4'hF, 4'hF, 4'h4);
        check("R6 no-register code never holds", got_stall, 0);

        // R9: reset during a hold empties the pipe and releases the reader
        issue(4'hF, 4'hF, 4'h3);
        dec_valid = 1'b1;
        dec_src   = {4'hF, 4'h3};
        dec_dst   = 4'h7;
        #1;
        check("R1 hold raised on match", int'(hold_decode), 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R9 hold cleared after reset", int'(hold_decode), 0);
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule